// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Event Codes

The block gathers 41 interrupt sources: fifteen external request lines with fixed levels, one non-maskable request at a level above every maskable one, and 25 on-chip peripheral events. It keeps the set of requests that are waiting and picks a winner. The highest level wins. Among waiting sources of equal level, the lower source index wins. The levels of the peripheral events come from three 16-bit level registers. In each register a 4-bit field is shared by a group of related events. Software writes and reads these registers through a small synchronous port.

A request line to the processor is raised when the set is not empty, the processor's block bit is clear, and the processor's mask level is strictly below the winner's level. When the processor pulses the accept strobe, the block removes the winner from the set and presents the winner's 12-bit event code. The code then holds until the next accept that finds a winner. Inside, a two-state occupancy machine tracks the set: ST_EMPTY means nothing is waiting and ST_LOADED means at least one request is waiting. The transition EMPTY_TO_LOADED happens on a raise that is recorded. LOADED_TO_EMPTY happens when an accept retires the last entry and no new raise arrives in that cycle. In all other cases the state holds, either as EMPTY_HOLD or as LOADED_HOLD.

Source index order (it sets the tie rule): 0-14 external lines 0-14, 15 non-maskable, 16 debug, 17 GPIO, 18-21 DMA channel ends 0-3, 22 DMA address error, 23-25 timers 0-2, 26 timer input capture, 27-29 RTC alarm/periodic/carry, 30-33 SCI error/receive/transmit/transmit-end, 34-37 SCIF events, 38 watchdog, 39 refresh compare, 40 refresh overflow.

Top module: `evt_intc`

## Requirements
- R1: After reset the set is empty, the state is ST_EMPTY, the request is low, the code output is 0x000, and all three level registers read 0.
- R2: The registers sit at address 0 (LA), 1 (LB) and 2 (LC). Each reads back exactly the 16 bits last written, including LB bits 3:0, which affect no level. Address 3 reads 0 and ignores writes.
- R3: The level fields are as follows. LA[15:12] sets timer 0 and LA[11:8] sets timer 1. LA[7:4] is shared by timer 2 and input capture, and LA[3:0] by the three RTC events. LB[15:12] sets the watchdog, LB[11:8] the two refresh events, and LB[7:4] the four SCI events. LC[15:12] sets GPIO, LC[11:8] all five DMA events, LC[7:4] the four SCIF events, and LC[3:0] debug.
- R4: External line n (0-14) has the fixed level 15-n. The non-maskable source has level 16.
- R5: A raise of a source whose level is 0 is not recorded.
- R6: Raising a source that is already waiting does not add a second entry. One accept retires it.
- R7: The winner is the waiting source with the highest level. At equal level, the lower source index wins.
- R8: The request is high only when the set is not empty, the block input is 0, and the mask input is strictly below the winner's level. It follows changes of mask and block without waiting for a clock edge.
- R9: An accept with a winner removes exactly that source one cycle later. An accept with an empty set changes nothing.
- R10: When a raise and an accept fall in the same cycle, the raise is recorded first, so the new source can be the one accepted.
- R11: The code output changes only on the edge that takes an accept with a winner. At other times it holds.
- R12: Event codes: external line n is 0x200+0x20·n, and the non-maskable source is 0x1C0. Timers 0-2 are 0x400/0x420/0x440 and capture is 0x460. RTC is 0x480/0x4A0/0x4C0, and SCI is 0x4E0-0x540 in steps of 0x20. Watchdog and the two refresh events are 0x560/0x580/0x5A0. Debug is 0x600 and GPIO is 0x620. DMA is 0x640-0x6C0 and SCIF is 0x700-0x760.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 41 | One-cycle raise strobe per source index |
| accept_i | input | 1 | Processor accept strobe |
| cpu_mask_i | input | 4 | Processor mask level |
| cpu_block_i | input | 1 | Processor block bit, 1 suppresses the request |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_req_o | output | 1 | Request to the processor |
| code_o | output | 12 | Event code of the last accepted source |

## Verification
The raise path and the accept path can act in the same cycle. A raise that is recorded then competes in the same cycle's selection for removal. The bench first leaves a low-level peripheral waiting. It then pulses a top-level external raise together with an accept. It expects the external line's code at once, with the peripheral still waiting and still requesting. A second accept must then return the peripheral's code.

// File: rtl/evt_intc_pkg.sv
package evt_intc_pkg;
    localparam int NSRC   = 41;
    localparam int PRI_W  = 4;
    localparam int LVL_W  = PRI_W + 1;
    localparam int CODE_W = 12;
    localparam int REG_W  = 16;
    localparam int NREG   = 3;
    localparam int ADDR_W = 2;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int NEXT   = 15;
    localparam int SRC_NMI = 15;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef enum logic {ST_EMPTY, ST_LOADED} occ_e;

    function automatic code_t src_code(input int i);
        int c;
        if (i < NEXT)            c = 'h200 + 'h20 * i;
        else if (i == SRC_NMI)   c = 'h1C0;
        else if (i == 16)        c = 'h600;
        else if (i == 17)        c = 'h620;
        else if (i <= 22)        c = 'h640 + 'h20 * (i - 18);
        else if (i <= 33)        c = 'h400 + 'h20 * (i - 23);
        else if (i <= 37)        c = 'h700 + 'h20 * (i - 34);
        else                     c = 'h560 + 'h20 * (i - 38);
        return code_t'(c);
    endfunction
endpackage

// File: rtl/evt_intc_levels.sv
module evt_intc_levels
    import evt_intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    output lvl_t [NSRC-1:0]           lvl_o
);
    logic [REG_W-1:0] regs_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs_q[r] <= '0;
            else if (we_i && addr_i == ADDR_W'(r))       regs_q[r] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NREG; r++)
            if (addr_i == ADDR_W'(r)) rdata_o = regs_q[r];
    end

    function automatic lvl_t fld(input logic [REG_W-1:0] v, input int n);
        return {1'b0, v[4*n +: PRI_W]};
    endfunction

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            if (i < NEXT)          lvl_o[i] = lvl_t'(NEXT - i);
            else if (i == SRC_NMI) lvl_o[i] = lvl_t'(16);
            else if (i == 16)      lvl_o[i] = fld(regs_q[2], 0);
            else if (i == 17)      lvl_o[i] = fld(regs_q[2], 3);
            else if (i <= 22)      lvl_o[i] = fld(regs_q[2], 2);
            else if (i == 23)      lvl_o[i] = fld(regs_q[0], 3);
            else if (i == 24)      lvl_o[i] = fld(regs_q[0], 2);
            else if (i <= 26)      lvl_o[i] = fld(regs_q[0], 1);
            else if (i <= 29)      lvl_o[i] = fld(regs_q[0], 0);
            else if (i <= 33)      lvl_o[i] = fld(regs_q[1], 1);
            else if (i <= 37)      lvl_o[i] = fld(regs_q[2], 1);
            else if (i == 38)      lvl_o[i] = fld(regs_q[1], 3);
            else                   lvl_o[i] = fld(regs_q[1], 2);
        end
    end
endmodule

// File: rtl/evt_intc_pick.sv
module evt_intc_pick
    import evt_intc_pkg::*;
(
    input  logic [NSRC-1:0]   pend_i,
    input  lvl_t [NSRC-1:0]   lvl_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o,
    output lvl_t              lvl_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i] && lvl_i[i] >= lvl_o) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/evt_intc.sv
module evt_intc
    import evt_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [40:0]       raise_i,
    input  logic              accept_i,
    input  logic [3:0]        cpu_mask_i,
    input  logic              cpu_block_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_req_o,
    output logic [11:0]       code_o
);
    lvl_t [NSRC-1:0]  lvl;
    logic [NSRC-1:0]  lvl_nz, pend_q, pend_mid, pend_d;
    logic             acc_any, req_any;
    logic [IDX_W-1:0] acc_idx, req_idx;
    lvl_t             acc_lvl, req_lvl;
    occ_e             state_q, state_d;
    code_t            code_q;

    evt_intc_levels u_levels (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .lvl_o(lvl)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_nz
        assign lvl_nz[i] = |lvl[i];
    end

    assign pend_mid = pend_q | (raise_i & lvl_nz);

    evt_intc_pick u_pick_acc (
        .pend_i(pend_mid), .lvl_i(lvl), .any_o(acc_any), .idx_o(acc_idx), .lvl_o(acc_lvl)
    );
    evt_intc_pick u_pick_req (
        .pend_i(pend_q), .lvl_i(lvl), .any_o(req_any), .idx_o(req_idx), .lvl_o(req_lvl)
    );

    always_comb begin
        pend_d = pend_mid;
        if (accept_i && acc_any) pend_d[acc_idx] = 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (|pend_d)  state_d = ST_LOADED;
            ST_LOADED: if (!(|pend_d)) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pend_q  <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (accept_i && acc_any) code_q <= src_code(int'(acc_idx));
        end
    end

    always_comb begin
        irq_req_o = 1'b0;
        unique case (state_q)
            ST_EMPTY:  irq_req_o = 1'b0;
            ST_LOADED: irq_req_o = req_any && !cpu_block_i &&
                                   ({1'b0, cpu_mask_i} < req_lvl);
        endcase
        code_o = code_q;
    end

    logic unused_ok;
    assign unused_ok = ^{acc_lvl, req_idx};
endmodule

// File: rtl/evt_intc_checker.sv
module evt_intc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [40:0] raise_i,
    input logic        accept_i,
    input logic        cpu_block_i,
    input logic        irq_req_o,
    input logic [11:0] code_o,
    input logic [40:0] pend_q
);
    assert_req_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (!cpu_block_i && pend_q != '0));

    assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(code_o));

    assert_retire_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && pend_q != '0 && raise_i == '0) |=>
        ($countones(pend_q) == $countones($past(pend_q)) - 1));

    assert_empty_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && pend_q == '0 && raise_i == '0) |=>
        ($stable(code_o) && pend_q == '0));

    assert_nmi_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_i[15] && !accept_i) |=> pend_q[15]);
endmodule

bind evt_intc evt_intc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .accept_i(accept_i),
    .cpu_block_i(cpu_block_i), .irq_req_o(irq_req_o), .code_o(code_o),
    .pend_q(pend_q)
);

// File: tb/evt_intc_bench.sv
module evt_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [40:0] raise = '0;
    logic        accept = 1'b0;
    logic [3:0]  mask = '0;
    logic        block = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_req;
    logic [11:0] code;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evt_intc u_evt_intc (
        .clk(clk), .rst_n(rst_n), .raise_i(raise), .accept_i(accept),
        .cpu_mask_i(mask), .cpu_block_i(block), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(irq_req), .code_o(code)
    );

    typedef struct packed {
        logic [5:0]  src;
        logic [3:0]  msk;
        logic        blk;
        logic        req;
        logic [11:0] cod;
    } vec_t;

    localparam vec_t TBL [17] = '{
        '{6'd0,  4'd14, 1'b0, 1'b1, 12'h200},
        '{6'd14, 4'd0,  1'b0, 1'b1, 12'h3C0},
        '{6'd14, 4'd1,  1'b0, 1'b0, 12'h3C0},
        '{6'd15, 4'd15, 1'b0, 1'b1, 12'h1C0},
        '{6'd15, 4'd0,  1'b1, 1'b0, 12'h1C0},
        '{6'd23, 4'd0,  1'b0, 1'b1, 12'h400},
        '{6'd24, 4'd2,  1'b0, 1'b0, 12'h420},
        '{6'd26, 4'd2,  1'b0, 1'b1, 12'h460},
        '{6'd28, 4'd3,  1'b0, 1'b1, 12'h4A0},
        '{6'd38, 4'd4,  1'b0, 1'b1, 12'h560},
        '{6'd40, 4'd6,  1'b0, 1'b0, 12'h5A0},
        '{6'd33, 4'd6,  1'b0, 1'b1, 12'h540},
        '{6'd17, 4'd7,  1'b0, 1'b1, 12'h620},
        '{6'd22, 4'd8,  1'b0, 1'b1, 12'h6C0},
        '{6'd37, 4'd9,  1'b0, 1'b1, 12'h760},
        '{6'd16, 4'd11, 1'b0, 1'b0, 12'h600},
        '{6'd7,  4'd7,  1'b0, 1'b1, 12'h2E0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        addr = a; #1;
        chk(req, 32'(rdata), 32'(exp));
    endtask

    task automatic raise_set(input logic [40:0] v);
        @(negedge clk); raise = v;
        @(negedge clk); raise = '0;
    endtask

    task automatic take;
        @(negedge clk); accept = 1'b1;
        @(negedge clk); accept = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", 32'(irq_req), 0);
        chk("R1 code", 32'(code), 0);
        rd_chk("R1 LA", 2'd0, 16'h0);
        rd_chk("R1 LB", 2'd1, 16'h0);
        rd_chk("R1 LC", 2'd2, 16'h0);

        // R2 readback, reserved bits kept, address 3 inert
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h567F);
        wr(2'd2, 16'h89AB);
        wr(2'd3, 16'hFFFF);
        rd_chk("R2 LA", 2'd0, 16'h1234);
        rd_chk("R2 LB", 2'd1, 16'h567F);
        rd_chk("R2 LC", 2'd2, 16'h89AB);
        rd_chk("R2 addr3", 2'd3, 16'h0);

        // R3/R4/R8/R12 table walk: one source at a time
        for (int k = 0; k < 17; k++) begin
            raise_set(41'(1) << TBL[k].src);
            mask = TBL[k].msk; block = TBL[k].blk; #1;
            chk("R8 R3 R4 req", 32'(irq_req), 32'(TBL[k].req));
            take();
            chk("R12 code", 32'(code), 32'(TBL[k].cod));
            mask = 4'd0; block = 1'b0; #1;
            chk("R9 retired", 32'(irq_req), 0);
        end

        // R9 accept on empty set leaves code
        take();
        chk("R9 empty accept", 32'(code), 32'h2E0);

        // R5 level-0 source ignored
        wr(2'd0, 16'h0234);
        raise_set(41'(1) << 23);
        chk("R5 req", 32'(irq_req), 0);
        take();
        chk("R5 code", 32'(code), 32'h2E0);
        wr(2'd0, 16'h1234);

        // R6 duplicate raise recorded once
        raise_set(41'(1) << 5);
        raise_set(41'(1) << 5);
        raise_set(41'(1) << 0);
        take();
        chk("R6 first", 32'(code), 32'h200);
        take();
        chk("R6 second", 32'(code), 32'h2A0);
        chk("R6 none left", 32'(irq_req), 0);

        // R7 ordering by level then index
        raise_set((41'(1) << 30) | (41'(1) << 33) | (41'(1) << 25) | (41'(1) << 40));
        take(); chk("R7 a", 32'(code), 32'h4E0);
        take(); chk("R7 b", 32'(code), 32'h540);
        take(); chk("R7 c", 32'(code), 32'h5A0);
        take(); chk("R7 d", 32'(code), 32'h440);
        raise_set((41'(1) << 17) | (41'(1) << 7));
        take(); chk("R7 tie ext", 32'(code), 32'h2E0);
        take(); chk("R7 tie gpio", 32'(code), 32'h620);

        // R8 mask and block changes act without a clock edge
        raise_set(41'(1) << 38);
        @(negedge clk); mask = 4'd5; #1;
        chk("R8 equal mask", 32'(irq_req), 0);
        mask = 4'd4; #1;
        chk("R8 lower mask", 32'(irq_req), 1);
        block = 1'b1; #1;
        chk("R8 blocked", 32'(irq_req), 0);
        block = 1'b0; mask = 4'd0;
        take(); chk("R8 drain", 32'(code), 32'h560);

        // R10 raise and accept in the same cycle
        raise_set(41'(1) << 40);
        @(negedge clk); raise = 41'(1); accept = 1'b1;
        @(negedge clk); raise = '0; accept = 1'b0;
        chk("R10 same cycle code", 32'(code), 32'h200);
        chk("R10 older still waiting", 32'(irq_req), 1);

        // R11 code holds across raises without accept
        raise_set(41'(1) << 1);
        repeat (3) @(negedge clk);
        chk("R11 hold", 32'(code), 32'h200);
        take(); chk("R11 next accept", 32'(code), 32'h220);
        take(); chk("R10 older after", 32'(code), 32'h5A0);

        // R1 reset mid-run empties the set
        raise_set(41'(1) << 2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 reset clears req", 32'(irq_req), 0);
        chk("R1 reset clears code", 32'(code), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule